// File: doc/BRIEF.md
# Multi-Mode Interval Counter Channel

This block is a single 16-bit binary down-counting timer channel. A host-side register block hands it a reload value and a mode code through a one-cycle load strobe. The channel then counts on a counter-clock enable (`cnt_en`) that is slower than the system clock. It drives one output line whose waveform depends on the mode: one-shot, retriggerable one-shot, rate pulse, square wave, software strobe or hardware strobe. The live count and the output level are both registered and exposed, so the surrounding logic can latch and read them back.

The `gate` input is interpreted per mode. In the level-gated modes (0 and 4) it suspends counting while low. In modes 1, 2, 3 and 5 a rising edge restarts the period from the most recently loaded value. A reload value of zero stands for a terminal count of 65536.

Control is a four-state machine:

- **IDLE**: the reset state; nothing has been loaded yet.
- **ARMED**: a first value has been loaded, and the channel waits for the first enable.
- **RUN**: counting.
- **PEND**: a reload is owed, because of a new load or a retrigger edge while counting.

Transitions:

- IDLE→ARMED on load.
- ARMED→RUN on `cnt_en`, which performs the reload.
- RUN→PEND on load or an accepted gate rise.
- PEND→RUN on `cnt_en`, which performs the reload.
- ARMED and PEND stay put if a new event arrives in the same cycle as the enable.

Top module: `ictr_top`

## Requirements
- R1: After reset `count` is 0 and `out` is low. Both stay there, whatever `cnt_en` and `gate` do, until a value has been loaded and a following `cnt_en` has occurred.
- R2: A load value of 0 means N = 65536. At the reload `count` shows 0x0000, and after one counting step it shows 0xFFFF.
- R3: A load captures value and mode in its cycle. The reload (count = N and elapsed d = 0) happens on the first `cnt_en` in a later cycle. A `cnt_en` in the same cycle as the load is a normal step under the old settings.
- R4: Mode 0: after a reload, `out` is low and `count` = (N − d) mod 2^16. `out` becomes high once d ≥ N and stays high until the next reload.
- R5: Mode 1: `count` and `out` behave as in mode 0. In addition, a rising `gate` edge while counting forces a reload at the next later `cnt_en`.
- R6: Mode 2: `count` = N − (d mod N), read mod 2^16. `out` is high for exactly the steps where d is a nonzero multiple of N.
- R7: Mode 3: `count` = N − (2d mod N), read mod 2^16. `out` is high when (d mod N) < (N+1)/2, and is high right after a reload.
- R8: Modes 4 and 5: `count` = (N − d) mod 2^16. `out` is high only while d = N.
- R9: In modes 0 and 4 a counting step happens only on a `cnt_en` where `gate` is high, and gate edges cause no reload. In modes 1, 2, 3 and 5 counting ignores the gate level, and a rising edge schedules a reload as in R5.
- R10: Mode codes 6 and 7 act exactly as modes 2 and 3.
- R11: In a cycle without `cnt_en`, `count` and `out` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Counter-clock enable, one system cycle per count |
| gate | input | 1 | Gate level; its meaning depends on the mode |
| load | input | 1 | One-cycle strobe that captures `load_val` and `load_mode` |
| load_val | input | 16 | Reload value, where 0 means 65536 |
| load_mode | input | 3 | Mode code 0 to 7 |
| count | output | 16 | Registered live count |
| out | output | 1 | Registered output level |

## Verification
The assertions assume the following about the inputs:

- `load` is a clean single-cycle strobe sampled on `clk`.
- `gate` is already synchronous to `clk`, so a rising edge is a one-cycle low-to-high change seen at two consecutive clock edges.
- `load_mode` carries any of the eight codes.

The stimulus drives every input half a period away from the sampling edge. It only ever changes `gate` as a whole-cycle level, which keeps every edge visible to the channel. It keeps reload values small in the mixed phase, so several full periods of each mode fit into the run. A reference model compares `count` and `out` after every clock, including cycles without an enable.

// File: rtl/ictr_pkg.sv
package ictr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_RUN,
        ST_PEND
    } ctl_state_t;

    typedef enum logic [2:0] {
        M_ONESHOT  = 3'd0,
        M_RETRIG   = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SWSTROBE = 3'd4,
        M_HWSTROBE = 3'd5
    } cmode_t;

    function automatic cmode_t map_mode(input logic [2:0] code);
        cmode_t m;
        unique case (code)
            3'd0: m = M_ONESHOT;
            3'd1: m = M_RETRIG;
            3'd2, 3'd6: m = M_RATE;
            3'd3, 3'd7: m = M_SQUARE;
            3'd4: m = M_SWSTROBE;
            default: m = M_HWSTROBE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ictr_ctrl.sv
module ictr_ctrl
    import ictr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cnt_en,
    input  logic   gate,
    input  logic   load,
    input  cmode_t mode_act,
    output logic   do_reload,
    output logic   do_step
);

    ctl_state_t state, state_nx;
    logic gate_q;
    logic level_gated;
    logic rise_ok;
    logic event_any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            gate_q <= 1'b0;
        end else begin
            state  <= state_nx;
            gate_q <= gate;
        end
    end

    always_comb begin
        level_gated = (mode_act == M_ONESHOT) || (mode_act == M_SWSTROBE);
        rise_ok     = gate && !gate_q && !level_gated;
        event_any   = load || rise_ok;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (load) state_nx = ST_ARMED;
            ST_ARMED: if (cnt_en && !load) state_nx = ST_RUN;
            ST_RUN:   if (event_any) state_nx = ST_PEND;
            ST_PEND:  if (cnt_en && !event_any) state_nx = ST_RUN;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        do_reload = 1'b0;
        do_step   = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_ARMED: do_reload = cnt_en;
            ST_RUN:   do_step   = cnt_en && (gate || !level_gated);
            ST_PEND:  do_reload = cnt_en;
            default:  ;
        endcase
    end

    // R9
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && (mode_act == M_ONESHOT || mode_act == M_SWSTROBE)) |-> !do_step);

    // R3
    one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_reload, do_step}));

    // R11
    no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |-> !(do_reload || do_step));

endmodule

// File: rtl/ictr_core.sv
module ictr_core
    import ictr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [2:0]   load_mode,
    input  logic         do_reload,
    input  logic         do_step,
    output cmode_t       mode_act,
    output logic [W-1:0] count_o,
    output logic         out_o
);

    localparam int NW = W + 1;
    localparam logic [NW-1:0] FULL = NW'(1) << W;

    logic [NW-1:0] n_pend, n_act;
    cmode_t        mode_pend;
    logic [NW-1:0] rem, cyc, t2, ph;
    logic [W-1:0]  cnt_q;
    logic          out_q;

    logic [NW-1:0] t_a, t_b, t_c, ph_inc, ph_n, half, rem_n, cyc_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_pend    <= FULL;
            mode_pend <= M_ONESHOT;
        end else if (load) begin
            n_pend    <= (load_val == '0) ? FULL : {1'b0, load_val};
            mode_pend <= map_mode(load_mode);
        end
    end

    always_comb begin
        t_a    = t2 + NW'(2);
        t_b    = (t_a >= n_act) ? t_a - n_act : t_a;
        t_c    = (t_b >= n_act) ? t_b - n_act : t_b;
        ph_inc = ph + NW'(1);
        ph_n   = (ph_inc == n_act) ? '0 : ph_inc;
        half   = (n_act + NW'(1)) >> 1;
        rem_n  = (rem == '0) ? '0 : rem - NW'(1);
        cyc_n  = (cyc == NW'(1)) ? n_act : cyc - NW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_act    <= FULL;
            mode_act <= M_ONESHOT;
            rem      <= '0;
            cyc      <= '0;
            t2       <= '0;
            ph       <= '0;
            cnt_q    <= '0;
            out_q    <= 1'b0;
        end else if (do_reload) begin
            n_act    <= n_pend;
            mode_act <= mode_pend;
            rem      <= n_pend;
            cyc      <= n_pend;
            t2       <= '0;
            ph       <= '0;
            cnt_q    <= n_pend[W-1:0];
            out_q    <= (mode_pend == M_SQUARE);
        end else if (do_step) begin
            unique case (mode_act)
                M_ONESHOT, M_RETRIG: begin
                    rem   <= rem_n;
                    cnt_q <= cnt_q - W'(1);
                    out_q <= (rem <= NW'(1));
                end
                M_SWSTROBE, M_HWSTROBE: begin
                    rem   <= rem_n;
                    cnt_q <= cnt_q - W'(1);
                    out_q <= (rem == NW'(1));
                end
                M_RATE: begin
                    cyc   <= cyc_n;
                    cnt_q <= cyc_n[W-1:0];
                    out_q <= (cyc == NW'(1));
                end
                M_SQUARE: begin
                    t2    <= t_c;
                    ph    <= ph_n;
                    cnt_q <= W'(n_act - t_c);
                    out_q <= (ph_n < half);
                end
                default: ;
            endcase
        end
    end

    assign count_o = cnt_q;
    assign out_o   = out_q;

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_reload && !do_step) |=> ($stable(cnt_q) && $stable(out_q)));

    // R4
    oneshot_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_act == M_ONESHOT && out_q && !do_reload) |=> out_q);

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_act == M_SWSTROBE || mode_act == M_HWSTROBE) && out_q && do_step) |=> !out_q);

    // R6
    rate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_act == M_RATE && out_q && do_step && n_act != NW'(1)) |=> !out_q);

endmodule

// File: rtl/ictr_top.sv
module ictr_top
    import ictr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         gate,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [2:0]   load_mode,
    output logic [W-1:0] count,
    output logic         out
);

    cmode_t mode_act;
    logic   do_reload;
    logic   do_step;

    ictr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .gate      (gate),
        .load      (load),
        .mode_act  (mode_act),
        .do_reload (do_reload),
        .do_step   (do_step)
    );

    ictr_core #(.W(W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_val  (load_val),
        .load_mode (load_mode),
        .do_reload (do_reload),
        .do_step   (do_step),
        .mode_act  (mode_act),
        .count_o   (count),
        .out_o     (out)
    );

endmodule

// File: tb/test_ictr_top.sv
module test_ictr_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        gate = 1'b0;
    logic        load = 1'b0;
    logic [15:0] load_val = '0;
    logic [2:0]  load_mode = '0;
    logic [15:0] count;
    logic        out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string req = "R1";

    always #5 clk = ~clk;

    ictr_top i_ictr_top (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate(gate), .load(load),
        .load_val(load_val), .load_mode(load_mode), .count(count), .out(out)
    );

    // behavioural reference: elapsed-count formulas
    int  m_n = 65536, m_m = 0, m_d = 0, p_n = 65536, p_m = 0;
    bit  started = 0, pend = 0, gq = 0;
    logic [15:0] m_cnt = '0;
    logic        m_out = 1'b0;

    function automatic void eval_out();
        int v;
        case (m_m)
            2: begin v = m_n - (m_d % m_n); m_out = ((m_d % m_n) == 0) && (m_d != 0); end
            3: begin v = m_n - ((2 * m_d) % m_n); m_out = (m_d % m_n) < ((m_n + 1) / 2); end
            4, 5: begin v = m_n - m_d; m_out = (m_d == m_n); end
            default: begin v = m_n - m_d; m_out = (m_d >= m_n); end
        endcase
        m_cnt = v[15:0];
    endfunction

    always @(posedge clk) begin
        bit rise, ev;
        if (!rst_n) begin
            started = 0; pend = 0; gq = 0; m_cnt = '0; m_out = 1'b0;
            m_m = 0; m_n = 65536;
        end else begin
            rise = gate && !gq;
            gq = gate;
            ev = load || (started && rise && !(m_m == 0 || m_m == 4));
            if (cnt_en) begin
                if (pend) begin
                    m_n = p_n; m_m = p_m; m_d = 0; started = 1; eval_out();
                end else if (started && (gate || !(m_m == 0 || m_m == 4))) begin
                    m_d++; eval_out();
                end
            end
            if (ev) pend = 1; else if (cnt_en) pend = 0;
            if (load) begin
                p_n = (load_val == 0) ? 65536 : int'(load_val);
                p_m = (load_mode > 5) ? int'(load_mode) - 4 : int'(load_mode);
            end
        end
    end

    task automatic compare();
        checks++;
        if (count !== m_cnt) begin
            errors++;
            $display("FAIL %s count actual %h expected %h", req, count, m_cnt);
        end
        checks++;
        if (out !== m_out) begin
            errors++;
            $display("FAIL %s out actual %b expected %b", req, out, m_out);
        end
    endtask

    task automatic tick(input bit ce);
        @(negedge clk);
        compare();
        load = 1'b0;
        cnt_en = ce;
    endtask

    task automatic ld(input int v, input int md, input bit ce);
        @(negedge clk);
        compare();
        load = 1'b1;
        load_val = v[15:0];
        load_mode = md[2:0];
        cnt_en = ce;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick(1'b1);
    endtask

    task automatic expect_now(input logic [15:0] c, input logic o);
        @(negedge clk);
        checks++;
        if (count !== c || out !== o) begin
            errors++;
            $display("FAIL %s direct actual %h/%b expected %h/%b", req, count, out, c, o);
        end
        load = 1'b0;
        cnt_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, enables with nothing loaded
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        gate = 1'b1;
        expect_now(16'h0000, 1'b0);
        run(5);
        // R3: load, idle cycles, then reload on enable; R11 holds without enable
        req = "R3";
        ld(5, 0, 1'b0);
        tick(0); tick(0);
        req = "R11";
        tick(1);
        tick(0); tick(0);
        expect_now(16'h0005, 1'b0);
        // R4: mode 0 through terminal count and beyond
        req = "R4";
        run(12);
        // R9: gate low suspends mode 0
        req = "R9";
        gate = 1'b0;
        run(4);
        ld(3, 0, 1'b1);
        run(3);
        gate = 1'b1;
        run(6);
        // R5: mode 1 with retrigger edges
        req = "R5";
        ld(4, 1, 1'b0);
        run(3);
        gate = 1'b0; tick(1);
        gate = 1'b1; run(8);
        gate = 1'b0; tick(0);
        gate = 1'b1; tick(0); tick(0);
        run(6);
        // R6: mode 2 with N = 3 and N = 1
        req = "R6";
        ld(3, 2, 1'b0);
        run(10);
        ld(1, 2, 1'b0);
        run(4);
        // R7: mode 3 odd and even N; R10: code 7 acts as 3, code 6 as 2
        req = "R7";
        ld(5, 3, 1'b0);
        run(12);
        ld(4, 3, 1'b0);
        run(9);
        req = "R10";
        ld(5, 7, 1'b0);
        run(11);
        ld(3, 6, 1'b0);
        run(7);
        // R8: mode 4 with gate pause, mode 5 with retrigger
        req = "R8";
        ld(3, 4, 1'b0);
        run(2);
        gate = 1'b0; run(3);
        gate = 1'b1; run(5);
        ld(3, 5, 1'b0);
        run(4);
        gate = 1'b0; tick(1);
        gate = 1'b1; run(6);
        // R2: zero load means 65536
        req = "R2";
        ld(0, 0, 1'b0);
        tick(1);
        expect_now(16'h0000, 1'b0);
        tick(1);
        expect_now(16'hFFFF, 1'b0);
        ld(0, 3, 1'b0);
        tick(1);
        tick(1);
        expect_now(16'hFFFE, 1'b1);
        // R3: load in same cycle as an enable steps under old settings
        req = "R3";
        ld(6, 2, 1'b0);
        run(3);
        ld(2, 0, 1'b1);
        run(5);
        // R9: mixed stimulus across all codes
        req = "R9";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            compare();
            load = ($urandom % 97) == 0;
            load_val = 16'($urandom % 9);
            load_mode = 3'($urandom % 8);
            cnt_en = ($urandom % 3) != 0;
            if (($urandom % 13) == 0) gate = ~gate;
        end
        tick(0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule